// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing side of a real-time clock. The host sees two addresses. A write to the even address selects one of 128 byte registers by index. A read or write at the odd address then reaches the selected register. Most indices act as plain storage. A few indices carry side effects:

- the calendar fields notify the time counter when they change;
- control register A protects its update-in-progress bit;
- control register B holds set mode and the interrupt enables;
- flag register C clears itself when read;
- status register D is a constant.

The time counter and the periodic generator sit outside the block. They reach it through plain side-band pins:

- `flag_set` sets event flags;
- `uip_set` and `uip_clr` move the update-in-progress bit;
- `evt_clear` is a soft clear of the enables and flags;
- the block returns `load_time`, a one-cycle strobe that tells the counter to take the calendar registers;
- `ctl_a` and `ctl_b` give the counter the current control settings.

Host accesses are single-cycle strobes. The port is always ready, so it has no back-pressure. Read data is registered and appears one cycle after the read strobe. If a read and a write of the data address fall in the same cycle, the read returns the value from before the write.

Top module: `rtc_host_port`

## Requirements
- R1: After reset, register 10 (A) reads 0x26, register 11 (B) reads 0x02, register 12 (C) reads 0x00, register 13 (D) reads 0x80, every other register reads 0x00, the index is 0 and `irq` is low.
- R2: A write with `host_sel`=0 stores `host_wdata[6:0]` as the index. A read with `host_sel`=0 returns 0xFF.
- R3: With `host_sel`=1, a write to any index other than 10 to 13 stores the byte, and a read returns the stored byte on `host_rdata` in the cycle after the read strobe.
- R4: A host write to A replaces A[6:0] and leaves A[7] (update in progress) at its previous value.
- R5: A host write to B with bit 7 (set mode) at 1 clears A[7] and stores bit 4 (update interrupt enable) as 0.
- R6: `load_time` pulses for one cycle, in the cycle after the write, in two cases: a host write to a calendar index (0, 2, 4, 6, 7, 8 or 9) made while B[7] is 0, and a host write to B with bit 7 at 0 made while B[7] is 1. No other write pulses it.
- R7: Host writes to C and D change nothing.
- R8: A read of C returns its current value, then C becomes 0x00 and `irq` drops.
- R9: `flag_set[3:0]` ORs into C[7:4] (7 = interrupt request, 6 = periodic, 5 = alarm, 4 = update ended). `flag_set[3]` raises `irq`. A flag set in the same cycle as a read of C wins.
- R10: `uip_set` sets A[7] only while B[7] is 0. `uip_clr` clears A[7] and wins over `uip_set`.
- R11: `evt_clear` clears B bits 6, 5 and 3 and C bits 7 to 4, and drops `irq`. It wins over any write or flag in the same cycle.
- R12: `ctl_a` and `ctl_b` always show the stored A and B, one cycle after the access that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the index address, 1 selects the data address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| flag_set | input | 4 | Event flags to set in C[7:4] |
| uip_set | input | 1 | Counter starts an update |
| uip_clr | input | 1 | Counter ends an update |
| evt_clear | input | 1 | Soft clear of the enables and flags |
| load_time | output | 1 | One-cycle strobe telling the counter to take the calendar registers |
| irq | output | 1 | Interrupt request |
| ctl_a | output | 8 | Current control register A |
| ctl_b | output | 8 | Current control register B |

## Verification
Every result is registered once. Read data, `load_time`, `irq`, `ctl_a` and `ctl_b` all change at the first rising edge after the strobe that caused them, and `load_time` falls again at the edge after that. The bench drives each operation on a falling edge and removes the strobes on the next falling edge. It compares all outputs at that point, after exactly one rising edge, against a bench-side reference. That reference takes every access, flag, update strobe and clear in the same cycle, following the priorities set out in the requirements.

// File: rtl/rtc_hp_pkg.sv
package rtc_hp_pkg;
  localparam int DATA_W = 8;

  localparam int IDX_CTLA  = 10;
  localparam int IDX_CTLB  = 11;
  localparam int IDX_FLAGC = 12;
  localparam int IDX_STATD = 13;

  localparam logic [DATA_W-1:0] RST_CTLA  = 8'h26;
  localparam logic [DATA_W-1:0] RST_CTLB  = 8'h02;
  localparam logic [DATA_W-1:0] RST_FLAGC = 8'h00;
  localparam logic [DATA_W-1:0] VAL_STATD = 8'h80;
  localparam logic [DATA_W-1:0] IDX_READ  = 8'hFF;

  localparam int BIT_UIP  = 7;  // A: update in progress
  localparam int BIT_SET  = 7;  // B: set mode
  localparam int BIT_UIEN = 4;  // B: update interrupt enable
  // B bits dropped by a soft clear: periodic, alarm, square-wave enables
  localparam logic [DATA_W-1:0] SOFT_CLR_B = 8'h68;

  typedef enum logic [2:0] {
    K_PLAIN, K_TIME, K_CTLA, K_CTLB, K_FLAGC, K_STATD
  } reg_kind_e;
endpackage

// File: rtl/rtc_hp_decode.sv
module rtc_hp_decode
  import rtc_hp_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind
);
  always_comb begin
    unique case (int'(idx))
      0, 2, 4, 6, 7, 8, 9: kind = K_TIME;
      IDX_CTLA:            kind = K_CTLA;
      IDX_CTLB:            kind = K_CTLB;
      IDX_FLAGC:           kind = K_FLAGC;
      IDX_STATD:           kind = K_STATD;
      default:             kind = K_PLAIN;
    endcase
  end
endmodule

// File: rtl/rtc_hp_store.sv
module rtc_hp_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wdata;
    end
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/rtc_hp_ctrl.sv
module rtc_hp_ctrl
  import rtc_hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              wr_time,
  input  logic              rd_c,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        flag_set,
  input  logic              uip_set,
  input  logic              uip_clr,
  input  logic              evt_clear,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_c,
  output logic              irq,
  output logic              load_time
);
  logic [DATA_W-1:0] a_n, b_n, c_n;
  logic              irq_n, load_n;

  always_comb begin
    a_n = reg_a;
    if (wr_a) a_n = {reg_a[BIT_UIP], wdata[BIT_UIP-1:0]};
    if (uip_clr) a_n[BIT_UIP] = 1'b0;
    else if (uip_set && !reg_b[BIT_SET]) a_n[BIT_UIP] = 1'b1;
    if (wr_b && wdata[BIT_SET]) a_n[BIT_UIP] = 1'b0;

    b_n = reg_b;
    if (wr_b) begin
      b_n = wdata;
      if (wdata[BIT_SET]) b_n[BIT_UIEN] = 1'b0;
    end
    if (evt_clear) b_n = b_n & ~SOFT_CLR_B;

    c_n   = rd_c ? '0 : reg_c;
    irq_n = rd_c ? 1'b0 : irq;
    c_n[7:4] = c_n[7:4] | flag_set;
    if (flag_set[3]) irq_n = 1'b1;
    if (evt_clear) begin
      c_n[7:4] = 4'h0;
      irq_n    = 1'b0;
    end

    load_n = (wr_time && !reg_b[BIT_SET]) ||
             (wr_b && !wdata[BIT_SET] && reg_b[BIT_SET]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a     <= RST_CTLA;
      reg_b     <= RST_CTLB;
      reg_c     <= RST_FLAGC;
      irq       <= 1'b0;
      load_time <= 1'b0;
    end else begin
      reg_a     <= a_n;
      reg_b     <= b_n;
      reg_c     <= c_n;
      irq       <= irq_n;
      load_time <= load_n;
    end
  end
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_hp_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [3:0]        flag_set,
  input  logic              uip_set,
  input  logic              uip_clr,
  input  logic              evt_clear,
  output logic              load_time,
  output logic              irq,
  output logic [DATA_W-1:0] ctl_a,
  output logic [DATA_W-1:0] ctl_b
);
  logic [IDX_W-1:0]  idx_q;
  reg_kind_e         kind;
  logic [DATA_W-1:0] store_q, reg_c, rd_mux;
  logic              dat_wr, dat_rd, store_we;

  assign dat_wr   = host_wr && host_sel;
  assign dat_rd   = host_rd && host_sel;
  assign store_we = dat_wr && (kind == K_PLAIN || kind == K_TIME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (host_wr && !host_sel) idx_q <= host_wdata[IDX_W-1:0];
  end

  rtc_hp_decode #(.IDX_W(IDX_W)) u_dec (
    .idx  (idx_q),
    .kind (kind)
  );

  rtc_hp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .idx   (idx_q),
    .wdata (host_wdata),
    .rdata (store_q)
  );

  rtc_hp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_a      (dat_wr && kind == K_CTLA),
    .wr_b      (dat_wr && kind == K_CTLB),
    .wr_time   (dat_wr && kind == K_TIME),
    .rd_c      (dat_rd && kind == K_FLAGC),
    .wdata     (host_wdata),
    .flag_set  (flag_set),
    .uip_set   (uip_set),
    .uip_clr   (uip_clr),
    .evt_clear (evt_clear),
    .reg_a     (ctl_a),
    .reg_b     (ctl_b),
    .reg_c     (reg_c),
    .irq       (irq),
    .load_time (load_time)
  );

  always_comb begin
    unique case (kind)
      K_CTLA:  rd_mux = ctl_a;
      K_CTLB:  rd_mux = ctl_b;
      K_FLAGC: rd_mux = reg_c;
      K_STATD: rd_mux = VAL_STATD;
      default: rd_mux = store_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) host_rdata <= host_sel ? rd_mux : IDX_READ;
  end
endmodule

// File: rtl/rtc_host_port_chk.sv
module rtc_host_port_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic             host_sel,
  input logic [7:0]       host_wdata,
  input logic [3:0]       flag_set,
  input logic             uip_set,
  input logic             uip_clr,
  input logic             evt_clear,
  input logic             load_time,
  input logic             irq,
  input logic [7:0]       ctl_a,
  input logic [7:0]       ctl_b,
  input logic [IDX_W-1:0] idx
);
  assert_a_uip_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && int'(idx) == 10 && !uip_set && !uip_clr)
      |=> ctl_a[7] == $past(ctl_a[7]));

  assert_set_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && int'(idx) == 11 && host_wdata[7])
      |=> (!ctl_b[4] && !ctl_a[7]));

  assert_load_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_time |-> $past(host_wr && host_sel));

  assert_c_read_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && int'(idx) == 12 && !flag_set[3]) |=> !irq);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set[3] && !evt_clear) |=> irq);

  assert_set_blocks_uip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[7] |-> !ctl_a[7]);

  assert_evt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (!irq && ctl_b[6:5] == 2'b00 && !ctl_b[3]));
endmodule

bind rtc_host_port rtc_host_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .flag_set   (flag_set),
  .uip_set    (uip_set),
  .uip_clr    (uip_clr),
  .evt_clear  (evt_clear),
  .load_time  (load_time),
  .irq        (irq),
  .ctl_a      (ctl_a),
  .ctl_b      (ctl_b),
  .idx        (idx_q)
);

// File: tb/tb_rtc_host_port.sv
module tb_rtc_host_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic [3:0] flag_set = 0;
  logic       uip_set = 0, uip_clr = 0, evt_clear = 0;
  logic       load_time, irq;
  logic [7:0] ctl_a, ctl_b;

  int  vec = 0, bad = 0;
  bit  done = 0;

  // reference state
  logic [7:0] m_mem [128];
  logic [6:0] m_idx;
  logic [7:0] m_a, m_b, m_c;
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_host_port dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .flag_set(flag_set), .uip_set(uip_set), .uip_clr(uip_clr),
    .evt_clear(evt_clear), .load_time(load_time), .irq(irq),
    .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  function automatic bit is_time(input logic [6:0] i);
    return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9;
  endfunction

  function automatic logic [7:0] ref_read(input logic [6:0] i);
    case (i)
      7'd10:   return m_a;
      7'd11:   return m_b;
      7'd12:   return m_c;
      7'd13:   return 8'h80;
      default: return m_mem[i];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation: drive on falling edge, update reference, compare after one rising edge
  task automatic op(input string tag, input bit wr, input bit rd, input bit sel,
                    input logic [7:0] wd, input logic [3:0] fs,
                    input bit us, input bit uc, input bit ec);
    logic [7:0] e_rd, na, nb, nc;
    logic       nirq, nload;
    bit         rdc;
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = wd;
    flag_set = fs; uip_set = us; uip_clr = uc; evt_clear = ec;
    e_rd  = sel ? ref_read(m_idx) : 8'hFF;
    na = m_a; nb = m_b;
    rdc = rd && sel && m_idx == 12;
    nc = rdc ? 8'h00 : m_c;
    nirq = rdc ? 1'b0 : m_irq;
    nload = 0;
    if (wr && !sel) m_idx = wd[6:0];
    if (wr && sel) begin
      if (m_idx == 10) na = {m_a[7], wd[6:0]};
      else if (m_idx == 11) begin
        nb = wd;
        if (wd[7]) nb[4] = 1'b0;
        nload = !wd[7] && m_b[7];
      end else if (m_idx != 12 && m_idx != 13) begin
        m_mem[m_idx] = wd;
        nload = is_time(m_idx) && !m_b[7];
      end
    end
    if (uc) na[7] = 0; else if (us && !m_b[7]) na[7] = 1;
    if (wr && sel && m_idx == 11 && wd[7]) na[7] = 0;
    nc[7:4] = nc[7:4] | fs;
    if (fs[3]) nirq = 1;
    if (ec) begin nb = nb & 8'h97; nc[7:4] = 0; nirq = 0; end
    m_a = na; m_b = nb; m_c = nc; m_irq = nirq;
    @(negedge clk);
    host_wr = 0; host_rd = 0; flag_set = 0; uip_set = 0; uip_clr = 0; evt_clear = 0;
    if (rd) chk(tag, host_rdata, e_rd);
    chk({tag, "/R6 load_time"}, {7'd0, load_time}, {7'd0, nload});
    chk({tag, "/R9 irq"}, {7'd0, irq}, {7'd0, nirq});
    chk({tag, "/R12 ctl_a"}, ctl_a, m_a);
    chk({tag, "/R12 ctl_b"}, ctl_b, m_b);
  endtask

  task automatic sel_idx(input int i);
    op("R2 index", 1, 0, 0, 8'(i), 0, 0, 0, 0);
  endtask

  task automatic wr_dat(input string t, input logic [7:0] d);
    op(t, 1, 0, 1, d, 0, 0, 0, 0);
  endtask

  task automatic rd_dat(input string t);
    op(t, 0, 1, 1, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    m_idx = 0; m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 ctl_a", ctl_a, 8'h26);
    chk("R1 ctl_b", ctl_b, 8'h02);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd_dat("R1 index0 reg");
    for (int i = 10; i < 14; i++) begin sel_idx(i); rd_dat("R1 ctrl reg"); end
    sel_idx(50); rd_dat("R1 plain reg");
    // R2 even read, index masks bit 7
    op("R2 even read", 0, 1, 0, 0, 0, 0, 0, 0);
    sel_idx(8'h85); wr_dat("R3 write", 8'h3C); sel_idx(5); rd_dat("R3 readback");
    // R4 protected bit
    op("R10 uip", 0, 0, 0, 0, 0, 1, 0, 0);
    sel_idx(10); wr_dat("R4 write A", 8'h00); rd_dat("R4 read A");
    // R5 set mode
    sel_idx(11); wr_dat("R5 set", 8'h9E); rd_dat("R5 read B");
    op("R10 uip blocked", 0, 0, 0, 0, 0, 1, 0, 0);
    // R6 no load while set, load on leaving set
    sel_idx(0); wr_dat("R6 time in set", 8'h45);
    sel_idx(11); wr_dat("R6 leave set", 8'h02);
    sel_idx(4); wr_dat("R6 time write", 8'h12);
    sel_idx(1); wr_dat("R6 alarm no load", 8'h12);
    // R7 C and D ignore writes
    op("R9 flags", 0, 0, 0, 0, 4'b0110, 0, 0, 0);
    sel_idx(12); wr_dat("R7 write C", 8'hFF); rd_dat("R8 read C");
    rd_dat("R8 C cleared");
    sel_idx(13); wr_dat("R7 write D", 8'h00); rd_dat("R7 read D");
    // R9 flag beats read clear
    op("R9 irq", 0, 0, 0, 0, 4'b1001, 0, 0, 0);
    sel_idx(12); op("R9 set vs clear", 0, 1, 1, 0, 4'b1000, 0, 0, 0);
    rd_dat("R9 C after");
    // R11 soft clear
    sel_idx(11); wr_dat("R11 prep", 8'h7A);
    op("R11 clear", 0, 0, 0, 0, 4'b1111, 0, 0, 1);
    rd_dat("R11 read B");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int k = int'($urandom_range(0, 9));
      logic [7:0] d = 8'($urandom);
      logic [3:0] fs = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      bit us = $urandom_range(0, 5) == 0;
      bit uc = $urandom_range(0, 7) == 0;
      bit ec = $urandom_range(0, 40) == 0;
      case (k)
        0, 1: op("R2 rnd index", 1, 0, 0, 8'($urandom_range(0, 15)), fs, us, uc, ec);
        2, 3: op("R3 rnd write", 1, 0, 1, d, fs, us, uc, ec);
        4, 5, 6: op("R3 rnd read", 0, 1, 1, d, fs, us, uc, ec);
        7: op("R3 rnd rd+wr", 1, 1, 1, d, fs, us, uc, ec);
        8: op("R2 rnd even read", 0, 1, 0, d, fs, us, uc, ec);
        default: op("R10 rnd side", 0, 0, 0, d, fs, us, uc, ec);
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule